// File: doc/BRIEF.md
# Idle Mode Power Controller

This block sequences a processor core between running and idle. Software sets an idle-enable bit and a two-bit clock select field through a small write port. A sleep strobe from the core then parks the CPU clock while the peripheral clock keeps running. When it enters idle, the block picks which oscillator drives the system. It bases that choice on the select field, on whether the secondary oscillator is enabled, and on the source already in use.

A wake event starts a fixed delay. During the delay the CPU clock stays gated. When the delay ends, the CPU clock returns on the same source that ran during idle, and a one-cycle resume pulse marks the point where instruction execution restarts. Status flags report whether the primary or the secondary oscillator is running the system clock. A separate output enables the primary oscillator.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset the block is in run on the primary source. In this state cpu_clk_en_o=1, per_clk_en_o=1, pri_osc_en_o=1, pri_running_o=1, sec_running_o=0, exec_resume_o=0, idle_en_o=0, clk_sel_o=00 and clk_src_o=00. The source codes are 00 primary, 01 secondary and 10 internal RC.
- R2: A cycle with cfg_we_i high loads cfg_idle_en_i and cfg_sel_i. The new values show on idle_en_o and clk_sel_o from the next cycle. A sleep strobe in that same cycle acts on the old values.
- R3: In run with idle_en_o=1, a sleep strobe drops cpu_clk_en_o from the next cycle, and per_clk_en_o stays 1. With idle_en_o=0, a sleep strobe is ignored and cpu_clk_en_o stays 1.
- R4: Idle entry with select 00 uses the primary source. This gives clk_src_o=00, pri_osc_en_o=1, pri_running_o=1 and sec_running_o=0.
- R5: Idle entry with select 01 and sec_osc_en_i=1 uses the secondary source. This gives clk_src_o=01, pri_osc_en_o=0, pri_running_o=0 and sec_running_o=1.
- R6: Idle entry with select 01 and sec_osc_en_i=0 keeps the source that was in use before. Idle entry with select 10 or 11 uses the RC source, which gives clk_src_o=10, pri_osc_en_o=1 and both running flags 0.
- R7: A wake event sampled in idle raises cpu_clk_en_o exactly WAKE_DLY cycles later, with the source unchanged. exec_resume_o is high for exactly that first running cycle.
- R8: A wake event leaves idle_en_o and clk_sel_o unchanged. After waking from secondary idle, sec_running_o stays 1 and pri_osc_en_o stays 0.
- R9: A wake event while running is ignored. A sleep strobe during the wake delay is ignored: the CPU clock returns on time and stays on.
- R10: The source changes only at idle entry. A write to the select field while running leaves clk_src_o and the running flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the control bits |
| cfg_idle_en_i | input | 1 | Idle-enable value to write |
| cfg_sel_i | input | 2 | Clock select value to write |
| sleep_i | input | 1 | One-cycle sleep request from the core |
| wake_i | input | 1 | Wake event |
| sec_osc_en_i | input | 1 | Secondary oscillator is enabled |
| idle_en_o | output | 1 | Current idle-enable bit |
| clk_sel_o | output | 2 | Current clock select field |
| clk_src_o | output | 2 | Active system clock source (00 primary, 01 secondary, 10 RC) |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| pri_running_o | output | 1 | Primary oscillator drives the system clock |
| sec_running_o | output | 1 | Secondary oscillator drives the system clock |
| exec_resume_o | output | 1 | One-cycle pulse when execution resumes |

## Verification
A sleep strobe or a control write sampled at one edge shows on the outputs after that same edge. The bench drives each stimulus for one cycle, waits past the capturing edge, and reads at the following falling edge. After a sampled wake, cpu_clk_en_o must stay low at every falling edge through WAKE_DLY-1 cycles. It must then be high together with exec_resume_o at the WAKE_DLY-th falling edge, and the pulse must be gone one cycle later. The checks for ignored stimuli read the gate enables, the source and the control bits in the cycle right after the stimulus, and again one cycle later.

// File: rtl/idle_pwr_pkg.sv
package idle_pwr_pkg;

    typedef enum logic [1:0] {
        SRC_PRI = 2'b00,
        SRC_SEC = 2'b01,
        SRC_RC  = 2'b10
    } clk_src_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_IDLE = 2'b01,
        ST_WAKE = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic       idle_en;
        logic [1:0] sel;
    } ctrl_t;

endpackage

// File: rtl/idle_ctrl_regs.sv
module idle_ctrl_regs
    import idle_pwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we_i,
    input  ctrl_t wdata_i,
    output ctrl_t ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we_i) begin
            ctrl_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{idle_en: 1'b0, sel: 2'b00};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/idle_src_pick.sv
module idle_src_pick
    import idle_pwr_pkg::*;
(
    input  clk_src_e   cur_i,
    input  logic [1:0] sel_i,
    input  logic       sec_en_i,
    output clk_src_e   nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        unique case (sel_i)
            2'b00: nxt_o = SRC_PRI;
            // Secondary is only taken if its oscillator is already enabled.
            2'b01: nxt_o = sec_en_i ? SRC_SEC : cur_i;
            default: nxt_o = SRC_RC;
        endcase
    end

endmodule

// File: rtl/idle_seq.sv
module idle_seq
    import idle_pwr_pkg::*;
#(
    parameter int unsigned WAKE_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_i,
    input  logic       idle_en_i,
    input  logic       wake_i,
    input  clk_src_e   pick_src_i,
    output seq_state_e state_o,
    output clk_src_e   src_o,
    output logic       resume_o
);

    localparam int unsigned CNT_W = (WAKE_DLY < 2) ? 1 : $clog2(WAKE_DLY);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_DLY - 1);

    typedef struct packed {
        seq_state_e       st;
        clk_src_e         src;
        logic [CNT_W-1:0] cnt;
        logic             resume;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        seq_d.resume = 1'b0;
        unique case (seq_q.st)
            ST_RUN: begin
                // Wake events are meaningless here and are dropped.
                if (sleep_i && idle_en_i) begin
                    seq_d.st  = ST_IDLE;
                    seq_d.src = pick_src_i;
                end
            end
            ST_IDLE: begin
                if (wake_i) begin
                    seq_d.st  = ST_WAKE;
                    seq_d.cnt = CNT_LOAD;
                end
            end
            ST_WAKE: begin
                // Sleep strobes while the delay runs are dropped.
                if (seq_q.cnt == '0) begin
                    seq_d.st     = ST_RUN;
                    seq_d.resume = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_RUN, src: SRC_PRI, cnt: '0, resume: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o  = seq_q.st;
    assign src_o    = seq_q.src;
    assign resume_o = seq_q.resume;

endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl
    import idle_pwr_pkg::*;
#(
    parameter int unsigned WAKE_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we_i,
    input  logic       cfg_idle_en_i,
    input  logic [1:0] cfg_sel_i,
    input  logic       sleep_i,
    input  logic       wake_i,
    input  logic       sec_osc_en_i,
    output logic       idle_en_o,
    output logic [1:0] clk_sel_o,
    output logic [1:0] clk_src_o,
    output logic       cpu_clk_en_o,
    output logic       per_clk_en_o,
    output logic       pri_osc_en_o,
    output logic       pri_running_o,
    output logic       sec_running_o,
    output logic       exec_resume_o
);

    ctrl_t      ctrl;
    clk_src_e   cur_src;
    clk_src_e   pick_src;
    seq_state_e state;

    idle_ctrl_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i ('{idle_en: cfg_idle_en_i, sel: cfg_sel_i}),
        .ctrl_o  (ctrl)
    );

    idle_src_pick i_pick (
        .cur_i    (cur_src),
        .sel_i    (ctrl.sel),
        .sec_en_i (sec_osc_en_i),
        .nxt_o    (pick_src)
    );

    idle_seq #(
        .WAKE_DLY (WAKE_DLY)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .idle_en_i  (ctrl.idle_en),
        .wake_i     (wake_i),
        .pick_src_i (pick_src),
        .state_o    (state),
        .src_o      (cur_src),
        .resume_o   (exec_resume_o)
    );

    assign idle_en_o     = ctrl.idle_en;
    assign clk_sel_o     = ctrl.sel;
    assign clk_src_o     = cur_src;
    assign cpu_clk_en_o  = (state == ST_RUN);
    // Peripherals stay clocked in every mode this block handles.
    assign per_clk_en_o  = 1'b1;
    assign pri_osc_en_o  = (cur_src != SRC_SEC);
    assign pri_running_o = (cur_src == SRC_PRI);
    assign sec_running_o = (cur_src == SRC_SEC);

endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we_i,
    input logic       sleep_i,
    input logic       wake_i,
    input logic       idle_en_o,
    input logic [1:0] clk_sel_o,
    input logic [1:0] clk_src_o,
    input logic       cpu_clk_en_o,
    input logic       pri_osc_en_o,
    input logic       pri_running_o,
    input logic       sec_running_o,
    input logic       exec_resume_o
);

    AST_SLEEP_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && idle_en_o && cpu_clk_en_o) |=> !cpu_clk_en_o); // R3

    AST_SLEEP_NO_IDLE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !idle_en_o && cpu_clk_en_o) |=> cpu_clk_en_o); // R3

    AST_PRI_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
        pri_running_o |-> pri_osc_en_o); // R4

    AST_SEC_PRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sec_running_o |-> !pri_osc_en_o); // R5

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pri_running_o, sec_running_o})); // R6

    AST_RESUME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_resume_o |-> (cpu_clk_en_o && !$past(cpu_clk_en_o))); // R7

    AST_RESUME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_resume_o |=> !exec_resume_o); // R7

    AST_WAKE_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_i && !cfg_we_i) |=> ($stable(idle_en_o) && $stable(clk_sel_o))); // R8

    AST_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_i && cpu_clk_en_o && !sleep_i) |=> cpu_clk_en_o); // R9

    AST_SRC_ONLY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_i && idle_en_o && cpu_clk_en_o) |=> $stable(clk_src_o)); // R10

endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we_i      (cfg_we_i),
    .sleep_i       (sleep_i),
    .wake_i        (wake_i),
    .idle_en_o     (idle_en_o),
    .clk_sel_o     (clk_sel_o),
    .clk_src_o     (clk_src_o),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .pri_osc_en_o  (pri_osc_en_o),
    .pri_running_o (pri_running_o),
    .sec_running_o (sec_running_o),
    .exec_resume_o (exec_resume_o)
);

// File: tb/test_idle_pwr_ctrl.sv
`timescale 1ns/1ps
module test_idle_pwr_ctrl;

    localparam int unsigned DLY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_en = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic       sleep = 1'b0;
    logic       wake = 1'b0;
    logic       sec_en = 1'b0;
    logic       idle_en_o, cpu_en, per_en, pri_osc, pri_run, sec_run, resume;
    logic [1:0] sel_o, src_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    idle_pwr_ctrl #(.WAKE_DLY(DLY)) i_idle_pwr_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we_i      (cfg_we),
        .cfg_idle_en_i (cfg_en),
        .cfg_sel_i     (cfg_sel),
        .sleep_i       (sleep),
        .wake_i        (wake),
        .sec_osc_en_i  (sec_en),
        .idle_en_o     (idle_en_o),
        .clk_sel_o     (sel_o),
        .clk_src_o     (src_o),
        .cpu_clk_en_o  (cpu_en),
        .per_clk_en_o  (per_en),
        .pri_osc_en_o  (pri_osc),
        .pri_running_o (pri_run),
        .sec_running_o (sec_run),
        .exec_resume_o (resume)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // flags packed as {pri_osc, pri_run, sec_run}
    function automatic logic [3:0] flags();
        return {1'b0, pri_osc, pri_run, sec_run};
    endfunction

    task automatic write_ctrl(logic en, logic [1:0] sel);
        cfg_we = 1'b1; cfg_en = en; cfg_sel = sel;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep = 1'b1;
        tick();
        sleep = 1'b0;
    endtask

    task automatic wake_up(string req, logic sleep_midway);
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk(req, "cpu off after wake", {3'b0, cpu_en}, 4'h0);
        for (int i = 1; i < DLY; i++) begin
            sleep = sleep_midway;
            tick();
            sleep = 1'b0;
            chk(req, "cpu still off in delay", {3'b0, cpu_en}, 4'h0);
        end
        tick();
        chk(req, "cpu on at delay end", {3'b0, cpu_en}, 4'h1);
        chk("R7", "resume pulse", {3'b0, resume}, 4'h1);
        tick();
        chk("R7", "resume pulse ends", {3'b0, resume}, 4'h0);
        chk(req, "cpu stays on", {3'b0, cpu_en}, 4'h1);
    endtask

    task automatic t_reset();
        chk("R1", "cpu_en", {3'b0, cpu_en}, 4'h1);
        chk("R1", "per_en", {3'b0, per_en}, 4'h1);
        chk("R1", "flags", flags(), 4'b0110);
        chk("R1", "resume", {3'b0, resume}, 4'h0);
        chk("R1", "ctrl", {1'b0, idle_en_o, sel_o}, 4'h0);
        chk("R1", "src", {2'b0, src_o}, 4'h0);
    endtask

    task automatic t_sleep_disabled();
        pulse_sleep();
        chk("R3", "sleep ignored without idle enable", {3'b0, cpu_en}, 4'h1);
    endtask

    task automatic t_write_and_same_cycle_sleep();
        cfg_we = 1'b1; cfg_en = 1'b1; cfg_sel = 2'b00; sleep = 1'b1;
        tick();
        cfg_we = 1'b0; sleep = 1'b0;
        chk("R2", "ctrl loaded", {1'b0, idle_en_o, sel_o}, 4'b0100);
        chk("R2", "sleep used old idle enable", {3'b0, cpu_en}, 4'h1);
    endtask

    task automatic t_wake_in_run();
        wake = 1'b1;
        tick();
        wake = 1'b0;
        chk("R9", "wake in run ignored", {3'b0, cpu_en}, 4'h1);
        chk("R9", "no resume in run", {3'b0, resume}, 4'h0);
    endtask

    task automatic t_pri_idle();
        pulse_sleep();
        chk("R3", "cpu gated", {3'b0, cpu_en}, 4'h0);
        chk("R3", "peripherals run", {3'b0, per_en}, 4'h1);
        chk("R4", "primary flags", flags(), 4'b0110);
        chk("R4", "src", {2'b0, src_o}, 4'h0);
        wake_up("R7", 1'b0);
        chk("R4", "primary flags after wake", flags(), 4'b0110);
        chk("R8", "ctrl after wake", {1'b0, idle_en_o, sel_o}, 4'b0100);
    endtask

    task automatic t_sec_fallback_from_pri();
        write_ctrl(1'b1, 2'b01);
        sec_en = 1'b0;
        pulse_sleep();
        chk("R6", "fallback keeps primary", {2'b0, src_o}, 4'h0);
        chk("R6", "fallback flags", flags(), 4'b0110);
        wake_up("R7", 1'b0);
    endtask

    task automatic t_sec_idle();
        sec_en = 1'b1;
        pulse_sleep();
        chk("R5", "src secondary", {2'b0, src_o}, 4'h1);
        chk("R5", "secondary flags", flags(), 4'b0001);
        wake_up("R7", 1'b0);
        chk("R8", "secondary kept after wake", flags(), 4'b0001);
        chk("R8", "ctrl after wake", {1'b0, idle_en_o, sel_o}, 4'b0101);
    endtask

    task automatic t_rc_idle();
        write_ctrl(1'b1, 2'b10);
        pulse_sleep();
        chk("R6", "src rc", {2'b0, src_o}, 4'h2);
        chk("R6", "rc flags", flags(), 4'b0100);
        wake_up("R7", 1'b0);
        write_ctrl(1'b1, 2'b01);
        sec_en = 1'b0;
        pulse_sleep();
        chk("R6", "fallback keeps rc", {2'b0, src_o}, 4'h2);
        wake_up("R9", 1'b1);
    endtask

    task automatic t_run_write();
        write_ctrl(1'b1, 2'b00);
        chk("R10", "write in run keeps src", {2'b0, src_o}, 4'h2);
        tick();
        chk("R10", "flags unchanged", flags(), 4'b0100);
        pulse_sleep();
        chk("R4", "entry now primary", {2'b0, src_o}, 4'h0);
        wake_up("R7", 1'b0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sleep_disabled();
        t_write_and_same_cycle_sleep();
        t_wake_in_run();
        t_pri_idle();
        t_sec_fallback_from_pri();
        t_sec_idle();
        t_rc_idle();
        t_run_write();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule